// File: doc/BRIEF.md
# Vector interrupt routing controller

This block collects up to 256 interrupt sources and steers each of them to one or more of four cores and to one of eight request lines per core. Every source has a sticky pending bit that is set by a rising edge. Software clears a pending bit by writing a one to it. A pending bit reaches a core only when its enable bit is set. Each source has its own routing byte. The low nibble of that byte selects the target cores, one bit per core, and the high nibble holds a destination node number that is stored but does not act in this single-node build. Sources are handled in groups of 32, and each group has its own byte that picks which request lines it drives.

Software reaches all of this through a simple 32-bit register port. The port has a write strobe, per-byte write enables and read data that appears one clock after the address. Two storage-only register arrays sit alongside the functional ones: a redirection word array and a node bitmap array. Both can be read and written, and neither has any effect on the outputs.

Top module: `irq_route_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero and every output request line is low.
- R2: A rising edge on source v sets its pending bit. The pending bit is read at byte offset 0x1800 + 4*(v>>5), bit v&31, which is the same layout as 64-bit status word v/64 at bit v%64 with the lower half first. An input that stays high does not set the bit again after it has been cleared.
- R3: A write to the status area clears each pending bit whose written data bit is one and whose byte enable is set. Bits in disabled byte lanes, and bits written as zero, keep their value.
- R4: When a rising edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The enable for source v is at offset 0x1600 + 4*(v>>5), bit v&31. A source whose enable is clear drives no request line, whatever its pending state.
- R6: The routing byte of source v is at offset 0x1c00 + v. Bits [3:0] are the one-hot core map and bits [7:4] are the stored node number. Byte enables let one byte change without disturbing the other three bytes of its word.
- R7: The line-select byte of group g = v>>5 is at offset 0x14c0 + g. Bit k of that byte drives request line k.
- R8: Output bit c*8+k is the OR, over all sources, of pending AND enabled AND core-map bit c AND group line bit k. A routing byte with several core bits set raises the request on every one of those cores.
- R9: Redirection words at 0x1680 (one per 32 sources) and node bitmap words at 0x14a0 (one per 32 sources) are read/write storage that honours byte enables and does not affect the outputs.
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change nothing.
- R11: Read data is registered. It shows the addressed word after the next clock edge and holds its previous value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 256 | Interrupt source inputs, rising-edge detected |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte enables for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 32 | Request lines, bit c*8+k = core c, line k |

## Verification
Each result in this block arrives exactly one clock edge after its cause. A read address produces data after the next edge. An input edge or a register write changes the pending, enable and routing state at the next edge, and the request lines follow that state combinationally. The driver applies stimulus just after a falling edge and tags each expected item with the cycle in which it falls due. The monitor compares each item at the falling edge that follows that rising edge. One check samples the read data before the edge, to confirm that the previous word is still held.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    // Number of sources served by one 32-bit enable/status word.
    localparam int GRP_SIZE = 32;

    // Byte offsets of each register area.
    localparam int OFS_NODEMAP = 'h14a0;
    localparam int OFS_LINESEL = 'h14c0;
    localparam int OFS_ENABLE  = 'h1600;
    localparam int OFS_REDIR   = 'h1680;
    localparam int OFS_STATUS  = 'h1800;
    localparam int OFS_ROUTE   = 'h1c00;

    typedef enum logic [2:0] {
        AREA_NONE,
        AREA_NODEMAP,
        AREA_LINESEL,
        AREA_ENABLE,
        AREA_REDIR,
        AREA_STATUS,
        AREA_ROUTE
    } area_e;

    typedef struct packed {
        area_e area;
        int    word;
    } reg_sel_t;

    typedef struct packed {
        logic [3:0] node;
        logic [3:0] cores;
    } route_byte_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

    // True when word address wa falls inside an area that starts at byte
    // offset base and is len words long.
    function automatic logic in_area(input int wa, input int base, input int len);
        return (wa >= (base >> 2)) && (wa < (base >> 2) + len);
    endfunction

endpackage

// File: rtl/irq_route_pending.sv
`timescale 1ns/1ps
module irq_route_pending
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] irq_in,
    input  logic [NUM_VEC-1:0] clr_mask,
    output logic [NUM_VEC-1:0] pend_q
);

    logic [NUM_VEC-1:0] in_q;
    logic [NUM_VEC-1:0] rise;

    assign rise = irq_in & ~in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q   <= '0;
            pend_q <= '0;
        end else begin
            in_q   <= irq_in;
            // A new edge wins over a clear that lands in the same cycle.
            pend_q <= (pend_q & ~clr_mask) | rise;
        end
    end

    // An edge always leaves its bit set, including when a clear arrives in the same cycle (R4).
    assert_edge_sets_pending_R2: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~rise) != '0) |=> ((pend_q & $past(clr_mask & ~rise)) == '0));

    assert_pending_holds_R2: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask == '0) && (rise == '0)) |=> $stable(pend_q));

endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [3:0]                    reg_be,
    input  logic [31:0]                   reg_wdata,
    input  logic [NUM_VEC-1:0]            pend_q,
    output logic [31:0]                   reg_rdata,
    output logic [NUM_VEC-1:0]            clr_mask,
    output logic [NUM_VEC-1:0]            en_q,
    output logic [NUM_VEC*NUM_CORES-1:0]  core_map,
    output logic [(NUM_VEC/GRP_SIZE)*NUM_LINES-1:0] line_sel
);

    localparam int NUM_GRP     = NUM_VEC / GRP_SIZE;
    localparam int GRP_WORDS   = NUM_GRP;
    localparam int LINE_WORDS  = (NUM_GRP + 3) / 4;
    localparam int ROUTE_WORDS = NUM_VEC / 4;

    logic [GRP_WORDS*32-1:0]   node_q;
    logic [LINE_WORDS*32-1:0]  line_q;
    logic [GRP_WORDS*32-1:0]   redir_q;
    logic [ROUTE_WORDS*32-1:0] route_q;

    reg_sel_t    sel;
    logic [31:0] rd_next;
    logic [31:0] wmask;

    assign wmask = lane_mask(reg_be);

    // Address decode: every area is word aligned.
    always_comb begin
        int wa;
        wa       = int'(reg_addr[ADDR_W-1:2]);
        sel.area = AREA_NONE;
        sel.word = 0;
        if (reg_addr[1:0] != 2'b00) begin
            sel.area = AREA_NONE;
        end else if (in_area(wa, OFS_NODEMAP, GRP_WORDS)) begin
            sel.area = AREA_NODEMAP;
            sel.word = wa - (OFS_NODEMAP >> 2);
        end else if (in_area(wa, OFS_LINESEL, LINE_WORDS)) begin
            sel.area = AREA_LINESEL;
            sel.word = wa - (OFS_LINESEL >> 2);
        end else if (in_area(wa, OFS_ENABLE, GRP_WORDS)) begin
            sel.area = AREA_ENABLE;
            sel.word = wa - (OFS_ENABLE >> 2);
        end else if (in_area(wa, OFS_REDIR, GRP_WORDS)) begin
            sel.area = AREA_REDIR;
            sel.word = wa - (OFS_REDIR >> 2);
        end else if (in_area(wa, OFS_STATUS, GRP_WORDS)) begin
            sel.area = AREA_STATUS;
            sel.word = wa - (OFS_STATUS >> 2);
        end else if (in_area(wa, OFS_ROUTE, ROUTE_WORDS)) begin
            sel.area = AREA_ROUTE;
            sel.word = wa - (OFS_ROUTE >> 2);
        end
    end

    // Read multiplexer, registered below.
    always_comb begin
        rd_next = '0;
        unique case (sel.area)
            AREA_NODEMAP: rd_next = node_q[sel.word*32 +: 32];
            AREA_LINESEL: rd_next = line_q[sel.word*32 +: 32];
            AREA_ENABLE:  rd_next = en_q[sel.word*32 +: 32];
            AREA_REDIR:   rd_next = redir_q[sel.word*32 +: 32];
            AREA_STATUS:  rd_next = pend_q[sel.word*32 +: 32];
            AREA_ROUTE:   rd_next = route_q[sel.word*32 +: 32];
            default:      rd_next = '0;
        endcase
    end

    // Write-one-to-clear mask for the pending bits.
    always_comb begin
        clr_mask = '0;
        if (reg_wr && sel.area == AREA_STATUS) begin
            clr_mask[sel.word*32 +: 32] = reg_wdata & wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            node_q    <= '0;
            line_q    <= '0;
            en_q      <= '0;
            redir_q   <= '0;
            route_q   <= '0;
            reg_rdata <= '0;
        end else begin
            reg_rdata <= rd_next;
            if (reg_wr) begin
                for (int b = 0; b < 4; b++) begin
                    if (reg_be[b]) begin
                        unique case (sel.area)
                            AREA_NODEMAP: node_q[sel.word*32 + b*8 +: 8]  <= reg_wdata[b*8 +: 8];
                            AREA_LINESEL: line_q[sel.word*32 + b*8 +: 8]  <= reg_wdata[b*8 +: 8];
                            AREA_ENABLE:  en_q[sel.word*32 + b*8 +: 8]    <= reg_wdata[b*8 +: 8];
                            AREA_REDIR:   redir_q[sel.word*32 + b*8 +: 8] <= reg_wdata[b*8 +: 8];
                            AREA_ROUTE:   route_q[sel.word*32 + b*8 +: 8] <= reg_wdata[b*8 +: 8];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // Core map and line selection handed to the fan-out logic.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_core
        route_byte_t rb;
        assign rb = route_q[v*8 +: 8];
        assign core_map[v*NUM_CORES +: NUM_CORES] = rb.cores[NUM_CORES-1:0];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_line
        assign line_sel[g*NUM_LINES +: NUM_LINES] = line_q[g*8 +: NUM_LINES];
    end

    assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (sel.area == AREA_NONE) |=> (reg_rdata == '0));

    assert_route_only_by_write_R6: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && sel.area == AREA_ROUTE) |=> $stable(route_q));

    assert_enable_only_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && sel.area == AREA_ENABLE) |=> $stable(en_q));

endmodule

// File: rtl/irq_route_fanout.sv
`timescale 1ns/1ps
module irq_route_fanout
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [NUM_VEC-1:0]                      pend_q,
    input  logic [NUM_VEC-1:0]                      en_q,
    input  logic [NUM_VEC*NUM_CORES-1:0]            core_map,
    input  logic [(NUM_VEC/GRP_SIZE)*NUM_LINES-1:0] line_sel,
    output logic [NUM_CORES*NUM_LINES-1:0]          irq_out
);

    logic [NUM_VEC-1:0] live;

    assign live = pend_q & en_q;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
            logic acc;
            always_comb begin
                acc = 1'b0;
                for (int v = 0; v < NUM_VEC; v++) begin
                    acc = acc | (live[v] & core_map[v*NUM_CORES + c]
                                 & line_sel[(v / GRP_SIZE)*NUM_LINES + k]);
                end
            end
            assign irq_out[c*NUM_LINES + k] = acc;
        end
    end

    assert_masked_silent_R5: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & en_q) == '0) |-> (irq_out == '0));

    assert_request_needs_source_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> ((pend_q & en_q) != '0));

endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_VEC   = 256,
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_VEC-1:0]             irq_in,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic                           reg_wr,
    input  logic [3:0]                     reg_be,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    output logic [NUM_CORES*NUM_LINES-1:0] irq_out
);

    localparam int NUM_GRP = NUM_VEC / GRP_SIZE;

    logic [NUM_VEC-1:0]           pend_q;
    logic [NUM_VEC-1:0]           clr_mask;
    logic [NUM_VEC-1:0]           en_q;
    logic [NUM_VEC*NUM_CORES-1:0] core_map;
    logic [NUM_GRP*NUM_LINES-1:0] line_sel;

    irq_route_pending #(.NUM_VEC(NUM_VEC)) u_pending (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .clr_mask (clr_mask),
        .pend_q   (pend_q)
    );

    irq_route_regs #(
        .NUM_VEC   (NUM_VEC),
        .NUM_CORES (NUM_CORES),
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .pend_q    (pend_q),
        .reg_rdata (reg_rdata),
        .clr_mask  (clr_mask),
        .en_q      (en_q),
        .core_map  (core_map),
        .line_sel  (line_sel)
    );

    irq_route_fanout #(
        .NUM_VEC   (NUM_VEC),
        .NUM_CORES (NUM_CORES),
        .NUM_LINES (NUM_LINES)
    ) u_fanout (
        .clk      (clk),
        .rst      (rst),
        .pend_q   (pend_q),
        .en_q     (en_q),
        .core_map (core_map),
        .line_sel (line_sel),
        .irq_out  (irq_out)
    );

endmodule

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] irq_in = '0;
    logic [15:0]  reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_be = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [31:0]  irq_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        bit          is_out;
        logic [31:0] exp;
        string       tag;
        int          due;
    } item_t;

    item_t sb[$];

    irq_route_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every expected item whose cycle has come.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_out ? irq_out : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input bit is_out, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_out = is_out;
        it.exp    = exp;
        it.tag    = tag;
        it.due    = cyc + 1;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        reg_wr = 1'b0; reg_addr = a;
        push(1'b0, exp, tag);
    endtask

    task automatic expect_out(input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        reg_wr = 1'b0;
        push(1'b1, exp, tag);
    endtask

    task automatic set_irq(input int v, input logic val);
        @(negedge clk); #1;
        reg_wr = 1'b0;
        irq_in[v] = val;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;

        // R1: reset state
        rd(16'h1600, 32'h0, "R1 enable word after reset");
        rd(16'h1800, 32'h0, "R1 status word after reset");
        rd(16'h1c00, 32'h0, "R1 route word after reset");
        expect_out(32'h0, "R1 outputs after reset");

        // R6: full word then a single-byte update of source 5 (word 1, lane 1)
        wr(16'h1c04, 4'b1111, 32'h44444444);
        wr(16'h1c04, 4'b0010, 32'hAAAA32AA);
        rd(16'h1c04, 32'h44443244, "R6 byte-masked route write");

        // R7: group 0 drives line 2
        wr(16'h14c0, 4'b0001, 32'h00000004);
        rd(16'h14c0, 32'h00000004, "R7 line select readback");

        // R2/R5: edge on disabled source 5 is pending but silent
        set_irq(5, 1'b1);
        rd(16'h1800, 32'h00000020, "R2 edge sets pending");
        expect_out(32'h0, "R5 disabled source silent");

        // R8: enable source 5 -> core 1 line 2 = bit 10
        wr(16'h1600, 4'b1111, 32'h00000020);
        expect_out(32'h00000400, "R8 core1 line2 request");

        // R3: clear it while input stays high (R2 level does not re-set)
        wr(16'h1800, 4'b1111, 32'h00000020);
        rd(16'h1800, 32'h0, "R3 w1c clears, R2 held level no re-set");
        expect_out(32'h0, "R3 request drops after clear");

        // R3: clear in a disabled byte lane has no effect
        set_irq(1, 1'b1);
        set_irq(1, 1'b0);
        wr(16'h1800, 4'b1110, 32'h00000002);
        rd(16'h1800, 32'h00000002, "R3 masked lane keeps pending");

        // R4: edge on source 3 coincides with clear of bits 1 and 3
        @(negedge clk); #1;
        irq_in[3] = 1'b1;
        reg_wr = 1'b1; reg_addr = 16'h1800; reg_be = 4'b0001; reg_wdata = 32'h0000000A;
        rd(16'h1800, 32'h00000008, "R4 coincident edge wins, R3 bit1 cleared");
        set_irq(3, 1'b0);

        // R11: read data holds the previous word until the edge
        rd(16'h1604, 32'h0, "R11 new read after edge");
        checks++;
        if (reg_rdata !== 32'h00000008) begin
            failures++;
            $display("FAIL R11 read data before edge actual=%h expected=%h", reg_rdata, 32'h8);
        end

        // R8: source 40 to cores 0 and 2 on line 7
        wr(16'h1c28, 4'b0001, 32'h00000005);
        wr(16'h14c0, 4'b0010, 32'h00008000);
        wr(16'h1604, 4'b1111, 32'h00000100);
        set_irq(40, 1'b1);
        set_irq(40, 1'b0);
        expect_out(32'h00800080, "R8 multi-core fan-out");
        rd(16'h1804, 32'h00000100, "R2 pending in upper status word");

        // R5: disable again
        wr(16'h1604, 4'b1111, 32'h0);
        expect_out(32'h0, "R5 disable masks request");

        // R9: storage-only arrays
        wr(16'h1684, 4'b1111, 32'hDEADBEEF);
        wr(16'h1684, 4'b0100, 32'h00110000);
        rd(16'h1684, 32'hDE11BEEF, "R9 redirection byte-masked");
        wr(16'h14a8, 4'b1111, 32'h12345678);
        rd(16'h14a8, 32'h12345678, "R9 node bitmap readback");
        expect_out(32'h0, "R9 storage has no output effect");

        // R10: unmapped and misaligned
        wr(16'h1000, 4'b1111, 32'hFFFFFFFF);
        rd(16'h1000, 32'h0, "R10 unmapped reads zero");
        rd(16'h1d00, 32'h0, "R10 past route table");
        wr(16'h1602, 4'b1111, 32'hFFFFFFFF);
        rd(16'h1600, 32'h00000020, "R10 misaligned write ignored");
        rd(16'h14c8, 32'h0, "R10 past line select");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule